// File: doc/BRIEF.md
# Serial Control-Register Port with Deferred Commit

This block is the slave side of a serial configuration port for a programmable frequency synthesizer. A host selects the port, then clocks in an instruction byte followed by a number of data bytes that depends on the register addressed. The instruction byte either writes a register or reads one back over the same bidirectional data pin. Written values go into a buffer bank only. The live control registers, which drive the synthesis core, copy the whole buffer bank at the rising edge of a separate update strobe. Several ports can therefore be loaded one after another and then switched over together with one strobe.

All serial inputs are brought into the system clock domain by two-flop synchronizers and are handled there by edge detection. The serial clock must therefore be much slower than the system clock. A transfer ends in one of three ways: the last data bit arrives, chip select rises, or the I/O reset input rises. After any of these, the next eight serial clock rising edges are taken as a fresh instruction byte.

Top module: `dds_ctrl_port`

## Requirements
- R1: After reset, every live register and every buffer register reads as zero.
- R2: The first eight serial clock rising edges of a transfer carry the instruction byte, most significant bit first. Bit 7 is 1 for a read and 0 for a write. Bits 3:0 give the register address. Bits 6:4 have no effect.
- R3: Register a transfers (a mod 4) + 1 data bytes, starting at the ninth rising edge, most significant bit first. The first byte is the most significant one. The value lands in the low bits of the 32-bit register and the upper bits are cleared.
- R4: A write changes only the buffer register. The live outputs stay unchanged until an update edge occurs.
- R5: A rising edge on upd copies all buffer registers into the live registers. The copy takes effect on the third system clock edge after upd rises. A high level or a falling edge on upd causes no further copy.
- R6: If an update edge and the completion of a write fall in the same system clock cycle, the live register takes the newly written value.
- R7: In the data phase of a read, the port drives sdio after each serial clock falling edge with the next bit of the addressed buffer register, most significant bit first, for the host to sample on the rising edge. sdio is released at all other times.
- R8: If cs_n rises before the last data bit, the transfer is dropped and no buffer register changes. The next transfer starts with an instruction byte.
- R9: While io_rst is high, the current transfer is aborted. After io_rst falls, the next eight rising edges form an instruction byte, even if cs_n stayed low throughout.
- R10: After the last data bit of a transfer, with cs_n still low, the next eight rising edges form the instruction byte of a new transfer.
- R11: An address of 4 or above writes nothing, and reading it returns zero. Its length still follows R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, idle low |
| sdio | inout | 1 | Bidirectional serial data |
| io_rst | input | 1 | Active-high serial transfer abort |
| upd | input | 1 | Update strobe, its rising edge commits the buffer bank |
| active_o | output | 128 | Live registers, register i at bits [32*i+31:32*i] |

## Verification
The completion of a write into the buffer bank and the commit of that bank to the live registers can land in the same system clock cycle. The bench provokes this by raising upd at the same instant as the final serial clock rising edge of a write. Both inputs pass through synchronizers of equal depth, so their edges are detected in the same cycle. The live register is then required to hold the new value on the third clock edge and not the old one. The bench also checks that the value is not yet visible one cycle earlier.

// File: rtl/dds_port_pkg.sv
package dds_port_pkg;
    typedef enum logic [0:0] {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    localparam int CMD_BITS  = 8;
    localparam int ADDR_BITS = 4;
endpackage

// File: rtl/dds_edge_sync.sv
module dds_edge_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d    = q;
        d.s1 = async_i;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{s1: RST_VAL, s2: RST_VAL, s3: RST_VAL};
        end else begin
            q <= d;
        end
    end

    assign level_o = q.s2;

    for (genvar i = 0; i < W; i++) begin : g_edge
        assign rise_o[i] = q.s2[i] & ~q.s3[i];
        assign fall_o[i] = ~q.s2[i] & q.s3[i];
    end
endmodule

// File: rtl/dds_serial_engine.sv
module dds_serial_engine
    import dds_port_pkg::*;
#(
    parameter int NREG      = 4,
    parameter int BYTES_MAX = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sdio_s,
    input  logic                   sclk_rise,
    input  logic                   sclk_fall,
    input  logic                   abort,
    input  logic [8*BYTES_MAX-1:0] rd_data,
    output logic [ADDR_BITS-1:0]   rd_addr,
    output logic                   wr_en,
    output logic [ADDR_BITS-1:0]   wr_addr,
    output logic [8*BYTES_MAX-1:0] wr_data,
    output logic                   oe,
    output logic                   dout
);
    localparam int REG_W  = 8 * BYTES_MAX;
    localparam int BYTE_W = (BYTES_MAX > 1) ? $clog2(BYTES_MAX) : 1;
    localparam int POS_W  = $clog2(REG_W);

    typedef struct packed {
        phase_e                phase;
        logic [2:0]            bit_cnt;
        logic [BYTE_W-1:0]     byte_cnt;
        logic                  rd;
        logic [ADDR_BITS-1:0]  addr;
        logic [CMD_BITS-2:0]   cmd;
        logic [REG_W-1:0]      acc;
        logic                  oe;
        logic                  dout;
    } eng_t;

    eng_t q, d;

    function automatic int len_of(input logic [ADDR_BITS-1:0] a);
        return (int'(a) % BYTES_MAX) + 1;
    endfunction

    int               nbytes;
    logic [REG_W-1:0] aligned;
    logic [POS_W-1:0] idx;
    logic [REG_W-1:0] acc_next;

    always_comb begin
        d        = q;
        wr_en    = 1'b0;
        nbytes   = len_of(q.addr);
        aligned  = rd_data << (8 * (BYTES_MAX - nbytes));
        idx      = POS_W'(REG_W - 1 - (int'(q.byte_cnt) * 8 + int'(q.bit_cnt)));
        acc_next = {q.acc[REG_W-2:0], sdio_s};

        if (abort) begin
            d.phase    = PH_CMD;
            d.bit_cnt  = '0;
            d.byte_cnt = '0;
            d.oe       = 1'b0;
        end else if (sclk_rise) begin
            d.bit_cnt = q.bit_cnt + 3'd1;
            if (q.phase == PH_CMD) begin
                d.cmd = {q.cmd[CMD_BITS-3:0], sdio_s};
                if (q.bit_cnt == 3'd7) begin
                    d.phase    = PH_DATA;
                    d.rd       = q.cmd[CMD_BITS-2];
                    d.addr     = {q.cmd[ADDR_BITS-2:0], sdio_s};
                    d.byte_cnt = '0;
                    d.acc      = '0;
                end
            end else begin
                d.acc = acc_next;
                if (q.bit_cnt == 3'd7) begin
                    if (int'(q.byte_cnt) == nbytes - 1) begin
                        d.phase    = PH_CMD;
                        d.byte_cnt = '0;
                        d.oe       = 1'b0;
                        wr_en      = !q.rd && (int'(q.addr) < NREG);
                    end else begin
                        d.byte_cnt = q.byte_cnt + BYTE_W'(1);
                    end
                end
            end
        end else if (sclk_fall && (q.phase == PH_DATA) && q.rd) begin
            d.oe   = 1'b1;
            d.dout = aligned[idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_addr = q.addr;
    assign wr_addr = q.addr;
    assign wr_data = acc_next;
    assign oe      = q.oe;
    assign dout    = q.dout;
endmodule

// File: rtl/dds_reg_bank.sv
module dds_reg_bank
    import dds_port_pkg::*;
#(
    parameter int NREG  = 4,
    parameter int REG_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_BITS-1:0]  wr_addr,
    input  logic [REG_W-1:0]      wr_data,
    input  logic                  commit,
    input  logic [ADDR_BITS-1:0]  rd_addr,
    output logic [REG_W-1:0]      rd_data,
    output logic [NREG*REG_W-1:0] shadow_o,
    output logic [NREG*REG_W-1:0] active_o
);
    typedef logic [NREG-1:0][REG_W-1:0] bank_t;

    typedef struct packed {
        bank_t shadow;
        bank_t active;
    } bank_st_t;

    bank_st_t q, d;

    always_comb begin
        d = q;
        for (int i = 0; i < NREG; i++) begin
            if (wr_en && (int'(wr_addr) == i)) begin
                d.shadow[i] = wr_data;
            end
        end
        if (commit) begin
            d.active = d.shadow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            if (int'(rd_addr) == i) begin
                rd_data = q.shadow[i];
            end
        end
    end

    assign shadow_o = q.shadow;
    assign active_o = q.active;
endmodule

// File: rtl/dds_ctrl_port.sv
module dds_ctrl_port
    import dds_port_pkg::*;
#(
    parameter int NREG      = 4,
    parameter int BYTES_MAX = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cs_n,
    input  logic                          sclk,
    inout  wire                           sdio,
    input  logic                          io_rst,
    input  logic                          upd,
    output logic [NREG*8*BYTES_MAX-1:0]   active_o
);
    localparam int REG_W = 8 * BYTES_MAX;
    localparam int NSYNC = 5;
    localparam int IX_SDIO = 0;
    localparam int IX_SCLK = 1;
    localparam int IX_CSN  = 2;
    localparam int IX_IORST = 3;
    localparam int IX_UPD  = 4;

    logic [NSYNC-1:0] sync_lvl, sync_rise, sync_fall;
    logic             abort, upd_rise;
    logic             wr_en, sdio_oe, sdio_dout;
    logic [ADDR_BITS-1:0] wr_addr, rd_addr;
    logic [REG_W-1:0]     wr_data, rd_data;
    logic [NREG*REG_W-1:0] shadow_flat;

    dds_edge_sync #(
        .W       (NSYNC),
        .RST_VAL (NSYNC'(1) << IX_CSN)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({upd, io_rst, cs_n, sclk, sdio}),
        .level_o (sync_lvl),
        .rise_o  (sync_rise),
        .fall_o  (sync_fall)
    );

    assign abort    = sync_lvl[IX_CSN] | sync_lvl[IX_IORST];
    assign upd_rise = sync_rise[IX_UPD];

    wire sync_unused = ^{sync_lvl[IX_SCLK], sync_lvl[IX_UPD], sync_rise[IX_SDIO],
                         sync_rise[IX_CSN], sync_rise[IX_IORST], sync_fall[IX_SDIO],
                         sync_fall[IX_CSN], sync_fall[IX_IORST], sync_fall[IX_UPD]};

    dds_serial_engine #(
        .NREG      (NREG),
        .BYTES_MAX (BYTES_MAX)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .sdio_s    (sync_lvl[IX_SDIO]),
        .sclk_rise (sync_rise[IX_SCLK]),
        .sclk_fall (sync_fall[IX_SCLK]),
        .abort     (abort),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .oe        (sdio_oe),
        .dout      (sdio_dout)
    );

    dds_reg_bank #(
        .NREG  (NREG),
        .REG_W (REG_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .commit   (upd_rise),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .shadow_o (shadow_flat),
        .active_o (active_o)
    );

    assign sdio = sdio_oe ? sdio_dout : 1'bz;
endmodule

// File: rtl/dds_port_chk.sv
module dds_port_chk #(
    parameter int NREG      = 4,
    parameter int BYTES_MAX = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          commit,
    input logic                          wr_en,
    input logic                          abort,
    input logic                          oe,
    input logic [NREG*8*BYTES_MAX-1:0]   shadow,
    input logic [NREG*8*BYTES_MAX-1:0]   active
);
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(active)); // R4

    AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (active == shadow)); // R5

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(shadow)); // R8

    AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !oe); // R9
endmodule

bind dds_ctrl_port dds_port_chk #(
    .NREG      (NREG),
    .BYTES_MAX (BYTES_MAX)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (upd_rise),
    .wr_en  (wr_en),
    .abort  (abort),
    .oe     (sdio_oe),
    .shadow (shadow_flat),
    .active (active_o)
);

// File: tb/sim_dds_ctrl_port.sv
module sim_dds_ctrl_port;
    localparam int NREG = 4;
    localparam int BYTES_MAX = 4;
    localparam int REG_W = 8 * BYTES_MAX;
    localparam int H = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic io_rst = 1'b0;
    logic upd = 1'b0;
    logic tb_oe = 1'b0;
    logic tb_bit = 1'b0;
    wire  sdio;
    logic [NREG*REG_W-1:0] active;

    assign sdio = tb_oe ? tb_bit : 1'bz;

    dds_ctrl_port #(.NREG(NREG), .BYTES_MAX(BYTES_MAX)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio(sdio),
        .io_rst(io_rst), .upd(upd), .active_o(active)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    logic [REG_W-1:0] sh_m [NREG];
    logic [REG_W-1:0] ac_m [NREG];
    logic rbit;

    task automatic check(input string req, input logic [REG_W-1:0] act, input logic [REG_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int len_of(input int a);
        return (a % BYTES_MAX) + 1;
    endfunction

    function automatic logic [REG_W-1:0] act_reg(input int i);
        return active[i*REG_W +: REG_W];
    endfunction

    function automatic logic [REG_W-1:0] trim(input int a, input logic [REG_W-1:0] v);
        return v & ({REG_W{1'b1}} >> (REG_W - 8 * len_of(a)));
    endfunction

    task automatic sbit(input logic b);
        @(negedge clk);
        tb_bit = b;
        sclk = 1'b0;
        repeat (H) @(negedge clk);
        rbit = sdio;
        sclk = 1'b1;
        repeat (H - 1) @(negedge clk);
    endtask

    task automatic sbyte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            sbit(b[i]);
            r[i] = rbit;
        end
    endtask

    task automatic select();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
    endtask

    task automatic deselect();
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * H) @(negedge clk);
    endtask

    task automatic wr_body(input int a, input logic [REG_W-1:0] v, input logic [2:0] junk);
        logic [7:0] r;
        tb_oe = 1'b1;
        sbyte({1'b0, junk, 4'(a)}, r);
        for (int k = len_of(a) - 1; k >= 0; k--) sbyte(v[8*k +: 8], r);
        if (a < NREG) sh_m[a] = trim(a, v);
    endtask

    task automatic rd_body(input int a, output logic [REG_W-1:0] v);
        logic [7:0] r;
        tb_oe = 1'b1;
        sbyte({1'b1, 3'b000, 4'(a)}, r);
        tb_oe = 1'b0;
        v = '0;
        for (int k = 0; k < len_of(a); k++) begin
            sbyte(8'h00, r);
            v = {v[REG_W-9:0], r};
        end
        tb_oe = 1'b1;
    endtask

    task automatic write_reg(input int a, input logic [REG_W-1:0] v);
        select();
        wr_body(a, v, 3'b000);
        deselect();
    endtask

    task automatic read_reg(input int a, output logic [REG_W-1:0] v);
        select();
        rd_body(a, v);
        deselect();
    endtask

    task automatic check_active(input string req);
        for (int i = 0; i < NREG; i++) check(req, act_reg(i), ac_m[i]);
    endtask

    task automatic pulse_update();
        @(negedge clk);
        upd = 1'b1;
        repeat (3) @(negedge clk);
        upd = 1'b0;
        for (int i = 0; i < NREG; i++) ac_m[i] = sh_m[i];
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [REG_W-1:0] v;
        check_active("R1 active after reset");
        read_reg(3, v);
        check("R1 buffer after reset", v, '0);
    endtask

    task automatic t_write_hold();
        logic [REG_W-1:0] v;
        write_reg(0, 32'hFFFF_FF3C);
        write_reg(1, 32'h0000_A55A);
        write_reg(2, 32'h0012_3456);
        write_reg(3, 32'hDEAD_BEEF);
        repeat (10) @(negedge clk);
        check_active("R4 live unchanged before update");
        read_reg(3, v);
        check("R7 readback reg3", v, 32'hDEAD_BEEF);
        read_reg(0, v);
        check("R3 one-byte reg0 trimmed", v, 32'h0000_003C);
        read_reg(2, v);
        check("R3 three-byte reg2", v, 32'h0012_3456);
    endtask

    task automatic t_update();
        @(negedge clk);
        upd = 1'b1;
        repeat (2) @(negedge clk);
        check("R5 no commit before third edge", act_reg(3), 32'h0);
        @(negedge clk);
        for (int i = 0; i < NREG; i++) ac_m[i] = sh_m[i];
        check_active("R5 commit on third edge");
        write_reg(0, 32'h0000_0081);
        repeat (10) @(negedge clk);
        check("R5 high level makes no commit", act_reg(0), ac_m[0]);
        upd = 1'b0;
        repeat (10) @(negedge clk);
        check("R5 falling edge makes no commit", act_reg(0), ac_m[0]);
        pulse_update();
        check("R5 second edge commits", act_reg(0), 32'h0000_0081);
    endtask

    task automatic t_cs_abort();
        logic [7:0] r;
        logic [REG_W-1:0] v;
        select();
        tb_oe = 1'b1;
        sbyte(8'h01, r);
        for (int i = 0; i < 5; i++) sbit(1'b1);
        deselect();
        read_reg(1, v);
        check("R8 partial write dropped", v, sh_m[1]);
    endtask

    task automatic t_iorst();
        logic [7:0] r;
        logic [REG_W-1:0] v;
        select();
        tb_oe = 1'b1;
        sbyte(8'h02, r);
        for (int i = 0; i < 5; i++) sbit(1'b0);
        @(negedge clk);
        io_rst = 1'b1;
        repeat (4) @(negedge clk);
        io_rst = 1'b0;
        repeat (4) @(negedge clk);
        wr_body(2, 32'h00C0_FFEE, 3'b000);
        deselect();
        read_reg(2, v);
        check("R9 fresh instruction after io_rst", v, 32'h00C0_FFEE);
    endtask

    task automatic t_back_to_back();
        logic [REG_W-1:0] v;
        select();
        wr_body(1, 32'h0000_1234, 3'b101);
        wr_body(3, 32'h0BAD_F00D, 3'b111);
        rd_body(1, v);
        deselect();
        check("R10 chained transfers readback", v, 32'h0000_1234);
        read_reg(3, v);
        check("R2 bits 6:4 ignored", v, 32'h0BAD_F00D);
    endtask

    task automatic t_unmapped();
        logic [REG_W-1:0] v;
        write_reg(9, 32'h0000_FFFF);
        write_reg(4, 32'h0000_00AA);
        for (int i = 0; i < NREG; i++) begin
            read_reg(i, v);
            check("R11 unmapped write discarded", v, sh_m[i]);
        end
        read_reg(9, v);
        check("R11 unmapped read zero", v, 32'h0);
    endtask

    task automatic t_coincide();
        logic [7:0] r;
        logic [7:0] val;
        val = 8'h5E;
        select();
        tb_oe = 1'b1;
        sbyte(8'h00, r);
        for (int i = 7; i >= 1; i--) sbit(val[i]);
        @(negedge clk);
        tb_bit = val[0];
        sclk = 1'b0;
        repeat (H) @(negedge clk);
        sclk = 1'b1;
        upd = 1'b1;
        repeat (2) @(negedge clk);
        check("R6 not visible before commit edge", act_reg(0), ac_m[0]);
        @(negedge clk);
        sh_m[0] = {24'h0, val};
        for (int i = 0; i < NREG; i++) ac_m[i] = sh_m[i];
        check("R6 coincident write committed", act_reg(0), {24'h0, val});
        check("R6 other register committed", act_reg(2), ac_m[2]);
        upd = 1'b0;
        deselect();
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) begin
            sh_m[i] = '0;
            ac_m[i] = '0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_hold();
        t_update();
        t_cs_abort();
        t_iorst();
        t_back_to_back();
        t_unmapped();
        pulse_update();
        check_active("R5 live matches buffer after commit");
        t_coincide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule